// File: doc/BRIEF.md
# Dual Potentiometer Serial Command Decoder

This block is the serial slave front end of a controller for two digital potentiometers. It runs on the chip's system clock and samples the serial clock, the active-low select, the pause input and the serial data input as ordinary signals. It finds edges of the serial clock inside the block. Each frame starts with an identification byte, which must carry the device-type nibble and the strapped address. An instruction byte follows. Depending on its opcode, the frame then ends, takes a data byte in, sends a register byte out, or enters an open-ended stepping mode that lasts until deselect.

Decoded work leaves the block as single-cycle command strobes to a register core. Each strobe carries an opcode, a pot index, a data-register index and a data byte. The register storage, the nonvolatile write timing and the wiper stepping arithmetic all live in that core. There is no back-pressure: the core must take every strobe on the cycle it is raised. For read opcodes the core must drive `rd_data` combinationally from the strobe fields during the strobe cycle. The serial output is a data pin plus an output-enable; the pad turns a low enable into high impedance.

Top module: `digpot_spi_frontend`

## Requirements
- R1: The first byte after a select falling edge must equal {4'b0101, 2'b00, dev_addr} (MSB first). Any other value makes the rest of the frame ignored, with no strobe.
- R2: After reset, no frame is decoded until a falling edge of `spi_cs_n` has been seen. Reset leaves `cmd_valid` and `spi_so_oe` low.
- R3: The instruction byte carries the opcode in bits 7:4, the data-register index in bits 3:2 and the pot index in bit 0; `cmd_op`, `cmd_reg` and `cmd_pot` copy these fields. A frame is dropped without a strobe if instruction bit 1 is 1, or if the opcode is not one of 0001, 0010, 0101, 1000, 1001, 1010, 1011, 1100, 1101, 1110.
- R4: The transfer opcodes 1101, 1110, 0001 and 1000 raise one strobe, with `cmd_data` = 0, once the 16th bit is received. Later bits in the frame have no effect.
- R5: The write opcodes 1010 (wiper) and 1100 (data register) raise one strobe once the 24th bit is received. `cmd_data` holds the third byte, first bit as MSB.
- R6: The read opcodes 1001 (wiper) and 1011 (data register) raise one strobe once the 16th bit is received and capture `rd_data` on the following cycle. The captured byte is driven on `spi_so` MSB first, one bit per falling serial-clock edge, starting with the falling edge after the 16th bit.
- R7: Opcode 0101 raises no strobe. It returns the byte {7'b0, wip_flag} on `spi_so`, with the same timing as R6.
- R8: After header opcode 0010, every further rising serial-clock edge until deselect raises a strobe with `cmd_op` = 0010, the header's pot and register index, and `cmd_data` = {7'b0, SI} (1 steps up, 0 steps down).
- R9: With `spi_cs_n` high, `spi_so_oe` is low and a partial frame is discarded. Strobes are raised only while the select is low.
- R10: `spi_hold_n` taken low while the serial clock is low pauses the frame. Clock edges are then ignored and `spi_so_oe` is low. Taking it high again while the clock is low resumes the frame with no bit lost.
- R11: Each strobe lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_hold_n | input | 1 | Active-low pause |
| spi_si | input | 1 | Serial data from the host |
| dev_addr | input | 2 | Strapped device address |
| wip_flag | input | 1 | Write-in-progress flag from the core |
| rd_data | input | 8 | Read byte from the core, valid during a read strobe |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Output enable for the serial data pad |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 4 | Command opcode |
| cmd_pot | output | 1 | Pot index |
| cmd_reg | output | 2 | Data-register index |
| cmd_data | output | 8 | Command data byte |

## Verification
The hardest situation to reach from the ports is a pause in the middle of an outbound read byte. The bench has to lower the pause input in a clock-low phase after part of the byte has been shifted out. It then toggles the serial clock while paused, so that a decoder which does not ignore those edges would lose or repeat bits, and releases the pause in another clock-low phase. The bench checks that the output enable is low during the pause and that the byte reassembled afterwards is intact. A separate frame applies a pause in the middle of an inbound data byte. Another hard case is a select that is already low when reset is released. The bench holds the select low through reset and sends a complete, valid frame that must produce nothing.

// File: rtl/digpot_spi_pkg.sv
package digpot_spi_pkg;

  localparam int BYTE_W   = 8;
  localparam int OP_W     = 4;
  localparam int REGSEL_W = 2;
  localparam int ADDR_W   = 2;
  localparam int BITCNT_W = $clog2(BYTE_W);

  localparam logic [OP_W-1:0] DEV_TYPE = 4'b0101;

  localparam logic [OP_W-1:0] OP_GLB_D2W  = 4'b0001;
  localparam logic [OP_W-1:0] OP_STEP     = 4'b0010;
  localparam logic [OP_W-1:0] OP_STATUS   = 4'b0101;
  localparam logic [OP_W-1:0] OP_GLB_W2D  = 4'b1000;
  localparam logic [OP_W-1:0] OP_RD_WIPER = 4'b1001;
  localparam logic [OP_W-1:0] OP_WR_WIPER = 4'b1010;
  localparam logic [OP_W-1:0] OP_RD_DREG  = 4'b1011;
  localparam logic [OP_W-1:0] OP_WR_DREG  = 4'b1100;
  localparam logic [OP_W-1:0] OP_D2W      = 4'b1101;
  localparam logic [OP_W-1:0] OP_W2D      = 4'b1110;

  typedef enum logic [2:0] {
    K_DROP, K_XFER, K_WRITE, K_READ, K_STATUS, K_STEP
  } kind_e;

  typedef enum logic [2:0] {
    F_ID, F_INSTR, F_WDATA, F_READ, F_STEP, F_IGNORE
  } frame_e;

  function automatic kind_e kind_of(logic [OP_W-1:0] op);
    case (op)
      OP_D2W, OP_W2D, OP_GLB_D2W, OP_GLB_W2D: return K_XFER;
      OP_WR_WIPER, OP_WR_DREG:                return K_WRITE;
      OP_RD_WIPER, OP_RD_DREG:                return K_READ;
      OP_STATUS:                              return K_STATUS;
      OP_STEP:                                return K_STEP;
      default:                                return K_DROP;
    endcase
  endfunction

endpackage

// File: rtl/digpot_spi_sampler.sv
module digpot_spi_sampler #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  // One capture stage; reset value 0 so a select held low at reset shows no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout <= '0;
    else        dout <= din;
  end
endmodule

// File: rtl/digpot_spi_classify.sv
module digpot_spi_classify
  import digpot_spi_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              id_ok,
  output logic [OP_W-1:0]   op,
  output logic [REGSEL_W-1:0] reg_idx,
  output logic              pot,
  output kind_e             kind
);
  localparam int PAD_W = BYTE_W - OP_W - ADDR_W;

  always_comb begin
    id_ok   = (byte_in[BYTE_W-1 -: OP_W] == DEV_TYPE) &&
              (byte_in[ADDR_W +: PAD_W] == '0) &&
              (byte_in[ADDR_W-1:0] == dev_addr);
    op      = byte_in[BYTE_W-1 -: OP_W];
    reg_idx = byte_in[2 +: REGSEL_W];
    pot     = byte_in[0];
    kind    = byte_in[1] ? K_DROP : kind_of(op);
  end
endmodule

// File: rtl/digpot_spi_shiftout.sv
module digpot_spi_shiftout #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         so
);
  logic [W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      so   <= 1'b0;
    end else if (clear) begin
      sreg <= '0;
      so   <= 1'b0;
    end else if (load) begin
      sreg <= load_val;
    end else if (shift) begin
      so   <= sreg[W-1];
      sreg <= {sreg[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/digpot_spi_frontend.sv
module digpot_spi_frontend
  import digpot_spi_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_sck,
  input  logic                spi_cs_n,
  input  logic                spi_hold_n,
  input  logic                spi_si,
  input  logic [ADDR_W-1:0]   dev_addr,
  input  logic                wip_flag,
  input  logic [BYTE_W-1:0]   rd_data,
  output logic                spi_so,
  output logic                spi_so_oe,
  output logic                cmd_valid,
  output logic [OP_W-1:0]     cmd_op,
  output logic                cmd_pot,
  output logic [REGSEL_W-1:0] cmd_reg,
  output logic [BYTE_W-1:0]   cmd_data
);
  localparam int PIN_W = 4;
  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);

  logic [PIN_W-1:0] pins_s;
  logic sck_c, csn_c, hold_c, si_c;
  logic sck_p, csn_p;

  digpot_spi_sampler #(.W(PIN_W)) u_sample (
    .clk (clk), .rst_n (rst_n),
    .din ({spi_sck, spi_cs_n, spi_hold_n, spi_si}),
    .dout(pins_s)
  );
  assign {sck_c, csn_c, hold_c, si_c} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= 1'b0;
      csn_p <= 1'b0;
    end else begin
      sck_p <= sck_c;
      csn_p <= csn_c;
    end
  end

  logic active, hold_act;
  logic cs_fall, run, rise, fall;

  assign cs_fall = csn_p & ~csn_c;
  assign run     = active & ~csn_c & ~hold_act;
  assign rise    = run & sck_c & ~sck_p;
  assign fall    = run & ~sck_c & sck_p;

  // Frame is armed only by a seen select falling edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       active <= 1'b0;
    else if (csn_c)   active <= 1'b0;
    else if (cs_fall) active <= 1'b1;
  end

  // Pause changes state only while the serial clock is low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hold_act <= 1'b0;
    else if (!active || csn_c) hold_act <= 1'b0;
    else if (!sck_c)           hold_act <= ~hold_c;
  end

  logic [BYTE_W-1:0]   sh_in, byte_next;
  logic [BITCNT_W-1:0] bitc;
  logic                byte_end;
  frame_e              fst;
  logic [OP_W-1:0]     op_q;
  logic [REGSEL_W-1:0] reg_q;
  logic                pot_q;
  logic                rd_load, st_load;

  assign byte_next = {sh_in[BYTE_W-2:0], si_c};
  assign byte_end  = rise && (bitc == LAST_BIT);

  logic                id_ok, c_pot;
  logic [OP_W-1:0]     c_op;
  logic [REGSEL_W-1:0] c_reg;
  kind_e               c_kind;

  digpot_spi_classify u_cls (
    .byte_in (byte_next), .dev_addr (dev_addr),
    .id_ok (id_ok), .op (c_op), .reg_idx (c_reg), .pot (c_pot), .kind (c_kind)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst       <= F_ID;
      bitc      <= '0;
      sh_in     <= '0;
      op_q      <= '0;
      reg_q     <= '0;
      pot_q     <= 1'b0;
      rd_load   <= 1'b0;
      st_load   <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_pot   <= 1'b0;
      cmd_reg   <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      rd_load   <= 1'b0;
      st_load   <= 1'b0;
      if (!active || csn_c) begin
        fst  <= F_ID;
        bitc <= '0;
      end else if (rise) begin
        sh_in <= byte_next;
        bitc  <= bitc + 1'b1;
        case (fst)
          F_ID: if (byte_end) fst <= id_ok ? F_INSTR : F_IGNORE;
          F_INSTR: if (byte_end) begin
            op_q  <= c_op;
            reg_q <= c_reg;
            pot_q <= c_pot;
            case (c_kind)
              K_XFER: begin
                cmd_valid <= 1'b1; cmd_op <= c_op; cmd_pot <= c_pot;
                cmd_reg <= c_reg; cmd_data <= '0;
                fst <= F_IGNORE;
              end
              K_READ: begin
                cmd_valid <= 1'b1; cmd_op <= c_op; cmd_pot <= c_pot;
                cmd_reg <= c_reg; cmd_data <= '0;
                rd_load <= 1'b1;
                fst <= F_READ;
              end
              K_STATUS: begin
                st_load <= 1'b1;
                fst <= F_READ;
              end
              K_WRITE: fst <= F_WDATA;
              K_STEP:  fst <= F_STEP;
              default: fst <= F_IGNORE;
            endcase
          end
          F_WDATA: if (byte_end) begin
            cmd_valid <= 1'b1; cmd_op <= op_q; cmd_pot <= pot_q;
            cmd_reg <= reg_q; cmd_data <= byte_next;
            fst <= F_IGNORE;
          end
          F_STEP: begin
            cmd_valid <= 1'b1; cmd_op <= op_q; cmd_pot <= pot_q;
            cmd_reg <= reg_q; cmd_data <= {{(BYTE_W-1){1'b0}}, si_c};
          end
          default: ;
        endcase
      end
    end
  end

  logic [BYTE_W-1:0] out_val;
  assign out_val = rd_load ? rd_data : {{(BYTE_W-1){1'b0}}, wip_flag};

  digpot_spi_shiftout #(.W(BYTE_W)) u_so (
    .clk (clk), .rst_n (rst_n),
    .clear (!active || csn_c),
    .load (rd_load | st_load), .load_val (out_val),
    .shift (fall && (fst == F_READ)),
    .so (spi_so)
  );

  assign spi_so_oe = active & ~csn_c & ~hold_act & (fst == F_READ);

endmodule

// File: rtl/digpot_spi_frontend_chk.sv
module digpot_spi_frontend_chk
  import digpot_spi_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            spi_cs_n,
  input logic            spi_so_oe,
  input logic            cmd_valid,
  input logic [OP_W-1:0] cmd_op
);
  // R11
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R3
  strobe_known_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (kind_of(cmd_op) != K_DROP));

  // R7
  status_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op != OP_STATUS));

  // R9
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n)) |-> !spi_so_oe);

  // R9
  strobe_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !$past(spi_cs_n, 2));
endmodule

bind digpot_spi_frontend digpot_spi_frontend_chk u_chk (
  .clk (clk), .rst_n (rst_n), .spi_cs_n (spi_cs_n),
  .spi_so_oe (spi_so_oe), .cmd_valid (cmd_valid), .cmd_op (cmd_op)
);

// File: tb/digpot_spi_frontend_tb_top.sv
module digpot_spi_frontend_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4;
  localparam logic [1:0] ADDR = 2'b10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0, spi_sck = 1'b0, spi_cs_n = 1'b0, spi_hold_n = 1'b1, spi_si = 1'b0;
  logic wip_flag = 1'b0;
  logic [7:0] rd_data;
  logic spi_so, spi_so_oe, cmd_valid, cmd_pot;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg;
  logic [7:0] cmd_data;

  function automatic logic [7:0] rdf(logic [3:0] op, logic pot, logic [1:0] rg);
    return {rg, pot, 1'b1, op} ^ 8'h5A;
  endfunction
  assign rd_data = rdf(cmd_op, cmd_pot, cmd_reg);

  digpot_spi_frontend dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_hold_n(spi_hold_n), .spi_si(spi_si), .dev_addr(ADDR), .wip_flag(wip_flag),
    .rd_data(rd_data), .spi_so(spi_so), .spi_so_oe(spi_so_oe), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data)
  );

  int checks = 0, errors = 0, strobes = 0;
  logic [14:0] exp_q[$];
  bit prev_v = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-clock comparison of strobes against the model queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid) begin
        strobes++;
        if (exp_q.size() == 0)
          chk(0, "R3 unexpected strobe", {cmd_op, cmd_pot, cmd_reg, cmd_data}, 0);
        else begin
          logic [14:0] e;
          e = exp_q.pop_front();
          chk({cmd_op, cmd_pot, cmd_reg, cmd_data} == e, "R4 R5 R6 R8 strobe fields",
              {cmd_op, cmd_pot, cmd_reg, cmd_data}, e);
        end
        if (prev_v) chk(0, "R11 strobe longer than one cycle", 1, 0);
      end
      prev_v = cmd_valid;
    end
  end

  task automatic bit_x(input bit b, output bit so_s, output bit oe_s);
    spi_si = b;
    repeat (HALF_SCK) @(negedge clk);
    so_s = spi_so; oe_s = spi_so_oe;
    spi_sck = 1'b1;
    repeat (HALF_SCK) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  task automatic pause(output bit oe_h);
    spi_hold_n = 1'b0;
    repeat (4) @(negedge clk);
    oe_h = spi_so_oe;
    for (int k = 0; k < 2; k++) begin
      spi_si = 1'b1; spi_sck = 1'b1; repeat (2) @(negedge clk);
      spi_sck = 1'b0; repeat (2) @(negedge clk);
    end
    spi_hold_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic byte_x(input logic [7:0] b, input int hold_at,
                        output logic [7:0] rx, output bit oe_all, output bit oe_h);
    bit s, o;
    oe_all = 1; oe_h = 0;
    for (int i = 7; i >= 0; i--) begin
      if (7 - i == hold_at) pause(oe_h);
      bit_x(b[i], s, o);
      rx[i] = s; oe_all &= o;
    end
  endtask

  task automatic sel();
    spi_cs_n = 1'b0; repeat (4) @(negedge clk);
  endtask
  task automatic desel();
    repeat (4) @(negedge clk); spi_cs_n = 1'b1; repeat (6) @(negedge clk);
  endtask

  // Behavioural model of one 24-bit frame.
  task automatic model(input logic [7:0] id, ins, dat, output bit rd, output logic [7:0] rb,
                       output int n);
    logic [3:0] op; op = ins[7:4];
    rd = 0; rb = 0; n = 0;
    if (id !== {4'b0101, 2'b00, ADDR} || ins[1]) return;
    if (op == 4'b1010 || op == 4'b1100) begin
      exp_q.push_back({op, ins[0], ins[3:2], dat}); n = 1;
    end else if (op == 4'b1101 || op == 4'b1110 || op == 4'b0001 || op == 4'b1000) begin
      exp_q.push_back({op, ins[0], ins[3:2], 8'h00}); n = 1;
    end else if (op == 4'b1001 || op == 4'b1011) begin
      exp_q.push_back({op, ins[0], ins[3:2], 8'h00}); n = 1;
      rd = 1; rb = rdf(op, ins[0], ins[3:2]);
    end else if (op == 4'b0101) begin
      rd = 1; rb = {7'b0, wip_flag};
    end
  endtask

  task automatic frame(input logic [7:0] id, ins, dat, input int hold_at, input string req);
    bit rd, oe, oh; logic [7:0] rb, rx, junk; int n, s0;
    model(id, ins, dat, rd, rb, n);
    s0 = strobes;
    sel();
    byte_x(id, -1, junk, oe, oh);
    byte_x(ins, -1, junk, oe, oh);
    byte_x(dat, hold_at, rx, oe, oh);
    desel();
    chk(strobes - s0 == n, {req, " strobe count"}, strobes - s0, n);
    if (rd) chk(rx == rb && oe, {req, " read byte"}, {oe, rx}, {1'b1, rb});
    if (hold_at >= 0) chk(!oh, "R10 output enabled during pause", oh, 0);
    chk(!spi_so_oe, "R9 output enabled after deselect", spi_so_oe, 0);
    exp_q.delete();
  endtask

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] junk; bit oe, oh; int s0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    chk(!cmd_valid && !spi_so_oe, "R2 reset state", {cmd_valid, spi_so_oe}, 0);
    // R2: select low through reset, valid frame ignored
    s0 = strobes;
    byte_x(8'h52, -1, junk, oe, oh);
    byte_x(8'hA1, -1, junk, oe, oh);
    byte_x(8'h3C, -1, junk, oe, oh);
    desel();
    chk(strobes == s0, "R2 frame without select edge", strobes - s0, 0);

    frame(8'h52, 8'hA1, 8'h3C, -1, "R5 write wiper");
    frame(8'h52, 8'hCC, 8'h96, -1, "R5 write data reg");
    frame(8'h52, 8'hD5, 8'hFF, -1, "R4 xfer d2w with trailing bits");
    frame(8'h52, 8'hE8, 8'h00, -1, "R4 xfer w2d");
    frame(8'h52, 8'h18, 8'hAA, -1, "R4 global d2w");
    frame(8'h52, 8'h88, 8'h55, -1, "R4 global w2d");
    frame(8'h52, 8'h90, 8'h00, -1, "R6 read wiper");
    frame(8'h52, 8'hB9, 8'h00, -1, "R6 read data reg");
    wip_flag = 1'b1;
    frame(8'h52, 8'h50, 8'h00, -1, "R7 status busy");
    wip_flag = 1'b0;
    frame(8'h52, 8'h50, 8'h00, -1, "R7 status idle");
    frame(8'h62, 8'hA1, 8'h3C, -1, "R1 bad device type");
    frame(8'h51, 8'hA1, 8'h3C, -1, "R1 address mismatch");
    frame(8'h56, 8'hA1, 8'h3C, -1, "R1 nonzero pad bits");
    frame(8'h52, 8'hA3, 8'h3C, -1, "R3 reserved bit set");
    frame(8'h52, 8'h30, 8'h3C, -1, "R3 undefined opcode 0011");
    frame(8'h52, 8'hF1, 8'h3C, -1, "R3 undefined opcode 1111");
    frame(8'h52, 8'hC5, 8'h6D, 3, "R10 pause in write data");
    frame(8'h52, 8'hB1, 8'h00, 3, "R10 pause in read data");

    // R8: stepping mode
    begin
      bit pat [5] = '{1, 1, 0, 1, 0};
      bit s, o;
      s0 = strobes;
      foreach (pat[i]) exp_q.push_back({4'b0010, 1'b1, 2'b00, 7'b0, pat[i]});
      sel();
      byte_x(8'h52, -1, junk, oe, oh);
      byte_x(8'h21, -1, junk, oe, oh);
      foreach (pat[i]) bit_x(pat[i], s, o);
      desel();
      chk(strobes - s0 == 5, "R8 step strobe count", strobes - s0, 5);
      exp_q.delete();
    end

    // R9: abort partial frame, then full frame
    begin
      bit s, o;
      s0 = strobes;
      sel();
      byte_x(8'h52, -1, junk, oe, oh);
      for (int i = 0; i < 4; i++) bit_x(1'b1, s, o);
      desel();
      chk(strobes == s0, "R9 aborted frame", strobes - s0, 0);
    end
    frame(8'h52, 8'hA0, 8'hC3, -1, "R9 frame after abort");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule